// File: doc/BRIEF.md
# Approximate FP32 Reciprocal Unit

This block returns a fast, table-based estimate of 1/x for one IEEE-754 single-precision operand. The estimate comes from a seed table indexed by the leading fraction bits, refined by a linear interpolation toward the next table point. The block places the estimate in bits 31:0 of a 128-bit result vector. Bits 127:32 of the result are copied from a 128-bit merge vector. In legacy mode the merge vector holds the destination's previous contents. In three-operand mode it holds a separate first source. Both modes use the same port, so the selection is made upstream.

Special operands follow fixed rules:
- A zero or denormal input yields an infinity with the input's sign.
- An infinity yields a signed zero.
- A signalling NaN is quietened; a quiet NaN passes through unchanged.
- Results that would fall below the normal range are flushed to zero with the operand's sign.

The block has no rounding-mode input and produces no exception indication.

The unit is a two-stage pipeline. It accepts one operand per clock, and each result appears exactly two clocks after its operand.

Top module: `rcp_pipe`

## Requirements
- R1: For a normal input whose result is not flushed, the relative error |r·x − 1| of the result r does not exceed 1.5×2^-12, and the result is a normal value with the operand's sign.
- R2: An input with exponent field (bits 30:23) equal to 0, whether zero or denormal, gives bits 31:0 = {input bit 31, 8'hFF, 23'd0}.
- R3: An input with exponent field 8'hFF and fraction field (bits 22:0) zero gives bits 31:0 = {input bit 31, 31'd0}.
- R4: An input with exponent field 8'hFF and a nonzero fraction gives the input with bit 22 forced to 1: a signalling NaN is quietened, and a quiet NaN is returned unchanged.
- R5: A magnitude at or above 1.00000000000110000000001b×2^126 gives {input bit 31, 31'd0}. A magnitude at or below 1.11111111110100000000000b×2^125 is never flushed.
- R6: An exact power of two 2^k (fraction field zero, exponent field 1 to 252) gives exactly 2^-k: exponent field 254 − e and fraction field zero.
- R7: Result bits 127:32 equal bits 127:32 of the merge vector presented with the operand, for either value of in_mode (0 = legacy, 1 = three-operand).
- R8: out_valid equals in_valid delayed by two clocks, and a new operand can be accepted on every clock.
- R9: While rst_n is low, out_valid and out_res are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 1 | Merge-mode select: 0 legacy, 1 three-operand (both read in_merge) |
| in_merge | input | 128 | Source of result bits 127:32 |
| in_op | input | 32 | FP32 operand |
| out_valid | output | 1 | Result strobe, two clocks after in_valid |
| out_res | output | 128 | Result vector; reciprocal in bits 31:0 |

## Verification
The assertions check the following on every cycle, using operands from two cycles earlier:
- the two-cycle valid alignment and upper-lane copy;
- the bit-exact special results for zero, denormal, infinity and NaN inputs;
- the flush of exponent-254 operands.

The accuracy bound exists only as a real-valued comparison, so only the bench can show it. The same holds for the flush boundaries near exponents 252 and 253, exact powers of two, and the indifference of the upper lane to in_mode. The bench shows these by comparing random and directed operands against a real-valued reciprocal.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  localparam int FRAC_W = 23;
  localparam int EXP_W  = 8;
  localparam int RCP_W  = FRAC_W + 2;   // reciprocal seed scaled by 2^(FRAC_W+1)

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opcls_e;

  // Operand class from exponent and fraction fields
  function automatic opcls_e classify(input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
    if (e == '0)            return CLS_ZERO;   // zero and denormal alike
    else if (e != '1)       return CLS_NORM;
    else if (f == '0)       return CLS_INF;
    else                    return CLS_NAN;
  endfunction

  // Biased result exponent: 253 - e, or 254 - e for an exact power of two.
  // Signed 10-bit so that a flush shows up as a value <= 0.
  function automatic logic signed [9:0] result_exp(input logic [EXP_W-1:0] e, input logic frac_zero);
    return 10'sd253 + (frac_zero ? 10'sd1 : 10'sd0) - $signed({2'b00, e});
  endfunction

  // Interpolate between two seeds by the fraction remainder t (tw bits used)
  function automatic logic [RCP_W-1:0] interp(input logic [RCP_W-1:0] y0,
                                             input logic [RCP_W-1:0] y1,
                                             input logic [FRAC_W-1:0] t,
                                             input int tw);
    logic [RCP_W+FRAC_W-1:0] prod;
    prod = (RCP_W+FRAC_W)'(y0 - y1) * (RCP_W+FRAC_W)'(t);
    return y0 - RCP_W'(prod >> tw);
  endfunction

endpackage

// File: rtl/rcp_seed_rom.sv
module rcp_seed_rom
  import rcp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [RCP_W-1:0] y_lo,
  output logic [RCP_W-1:0] y_hi
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam longint NUMER = longint'(1) << (FRAC_W + 1 + IDX_W);

  // Point k holds 2^(FRAC_W+1) / (1 + k/ENTRIES), for k = 0..ENTRIES
  logic [RCP_W-1:0] seed [0:ENTRIES];

  for (genvar gk = 0; gk <= ENTRIES; gk++) begin : g_seed
    localparam longint VAL = NUMER / (longint'(ENTRIES) + longint'(gk));
    assign seed[gk] = RCP_W'(VAL);
  end

  logic [IDX_W:0] idx_next;
  assign idx_next = {1'b0, idx} + 1'b1;

  assign y_lo = seed[idx];
  assign y_hi = seed[idx_next];

endmodule

// File: rtl/rcp_interp.sv
module rcp_interp
  import rcp_pkg::*;
#(
  parameter int T_W = 15
) (
  input  logic [RCP_W-1:0] y_lo,
  input  logic [RCP_W-1:0] y_hi,
  input  logic [T_W-1:0]   t,
  output logic [RCP_W-1:0] y
);
  assign y = interp(y_lo, y_hi, FRAC_W'(t), T_W);
endmodule

// File: rtl/rcp_pipe.sv
module rcp_pipe
  import rcp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_mode,
  input  logic [VEC_W-1:0] in_merge,
  input  logic [31:0]      in_op,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_res
);
  localparam int T_W  = FRAC_W - IDX_W;
  localparam int UP_W = VEC_W - 32;

  // Both merge modes read the same port: the upper lane source is chosen upstream
  logic unused_mode;
  assign unused_mode = in_mode;

  // ---------------- stage 1: classify and seed lookup ----------------
  logic [RCP_W-1:0] seed_lo, seed_hi;

  rcp_seed_rom #(.IDX_W(IDX_W)) u_rom (
    .idx  (in_op[FRAC_W-1 -: IDX_W]),
    .y_lo (seed_lo),
    .y_hi (seed_hi)
  );

  logic              s1_vld;
  opcls_e            s1_cls;
  logic              s1_sign;
  logic [EXP_W-1:0]  s1_exp;
  logic [FRAC_W-1:0] s1_frac;
  logic [RCP_W-1:0]  s1_ylo, s1_yhi;
  logic [UP_W-1:0]   s1_upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_cls   <= CLS_ZERO;
      s1_sign  <= 1'b0;
      s1_exp   <= '0;
      s1_frac  <= '0;
      s1_ylo   <= '0;
      s1_yhi   <= '0;
      s1_upper <= '0;
    end else begin
      s1_vld   <= in_valid;
      s1_cls   <= classify(in_op[30:23], in_op[22:0]);
      s1_sign  <= in_op[31];
      s1_exp   <= in_op[30:23];
      s1_frac  <= in_op[22:0];
      s1_ylo   <= seed_lo;
      s1_yhi   <= seed_hi;
      s1_upper <= in_merge[VEC_W-1:32];
    end
  end

  // ---------------- stage 2: interpolate, exponent, special cases ----------------
  logic [RCP_W-1:0] mant_est;

  rcp_interp #(.T_W(T_W)) u_interp (
    .y_lo (s1_ylo),
    .y_hi (s1_yhi),
    .t    (s1_frac[T_W-1:0]),
    .y    (mant_est)
  );

  // Named events for the checker
  logic              frac_zero;
  logic signed [9:0] rexp;
  logic              flush_hit;
  logic              nan_hit;
  logic [31:0]       lane_res;

  assign frac_zero = (s1_frac == '0);
  assign rexp      = result_exp(s1_exp, frac_zero);
  assign flush_hit = (s1_cls == CLS_NORM) && (rexp <= 10'sd0);
  assign nan_hit   = (s1_cls == CLS_NAN);

  always_comb begin
    unique case (s1_cls)
      CLS_ZERO: lane_res = {s1_sign, 8'hFF, 23'd0};
      CLS_INF:  lane_res = {s1_sign, 31'd0};
      CLS_NAN:  lane_res = {s1_sign, 8'hFF, 1'b1, s1_frac[21:0]};
      default: begin
        if (flush_hit)
          lane_res = {s1_sign, 31'd0};
        else
          lane_res = {s1_sign, rexp[7:0], frac_zero ? 23'd0 : mant_est[FRAC_W-1:0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= s1_vld;
      out_res   <= {s1_upper, lane_res};
    end
  end

endmodule

// File: rtl/rcp_pipe_chk.sv
module rcp_pipe_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [VEC_W-1:0] in_merge,
  input logic [31:0]      in_op,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_res,
  input logic             s1_vld,
  input logic             s1_sign,
  input logic             flush_hit,
  input logic             nan_hit
);
  // Clocks since reset release, saturating; guards the two-deep $past
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  logic warm;
  assign warm = (age >= 2'd2);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 2)));

  p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> (out_res[VEC_W-1:32] == $past(in_merge[VEC_W-1:32], 2)));

  p_zero_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid && (in_op[30:23] == 8'h00), 2))
      |-> (out_res[31:0] == {$past(in_op[31], 2), 8'hFF, 23'd0}));

  p_inf_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid && (in_op[30:0] == {8'hFF, 23'd0}), 2))
      |-> (out_res[31:0] == {$past(in_op[31], 2), 31'd0}));

  p_nan_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && nan_hit) |=> (out_res[30:22] == 9'h1FF));

  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && flush_hit) |=> (out_res[31:0] == {$past(s1_sign), 31'd0}));

  p_exp254_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid && (in_op[30:23] == 8'd254), 2)) |-> (out_res[30:0] == 31'd0));

  always_comb begin
    if (!rst_n) begin
      p_reset_r9: assert (!out_valid && (out_res == '0));
    end
  end

endmodule

bind rcp_pipe rcp_pipe_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_merge  (in_merge),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_res   (out_res),
  .s1_vld    (s1_vld),
  .s1_sign   (s1_sign),
  .flush_hit (flush_hit),
  .nan_hit   (nan_hit)
);

// File: tb/tb_rcp_pipe.sv
module tb_rcp_pipe;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_mode = 1'b0;
  logic [127:0] in_merge = '0;
  logic [31:0]  in_op = '0;
  logic         out_valid;
  logic [127:0] out_res;

  always #4 clk = ~clk;   // 125 MHz

  rcp_pipe dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_mode (in_mode),
    .in_merge (in_merge), .in_op (in_op), .out_valid (out_valid), .out_res (out_res)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;

  logic [31:0]  q_op  [$];
  logic [95:0]  q_up  [$];
  int unsigned  q_cyc [$];

  always @(posedge clk) cyc <= cyc + 1;

  localparam real ERR_MAX = 1.5 / 4096.0;
  localparam logic [22:0] KEEP_FRAC  = 23'b11111111110100000000000;  // at exp 252
  localparam logic [22:0] FLUSH_FRAC = 23'b00000000000110000000001;  // at exp 253

  function automatic real f2r(input logic [31:0] b);
    logic [63:0] d;
    d = {b[31], 11'(b[30:23]) + 11'd896, b[22:0], 29'd0};
    return $bitstoreal(d);
  endfunction

  function automatic bit err_ok(input logic [31:0] x, input logic [31:0] r);
    real e;
    if (r[30:23] == 8'h00 || r[30:23] == 8'hFF || r[31] != x[31]) return 1'b0;
    e = f2r(r) * f2r(x) - 1.0;
    if (e < 0.0) e = -e;
    return e <= ERR_MAX;
  endfunction

  task automatic report(input bit ok, input string req, input logic [31:0] x,
                        input logic [127:0] got, input logic [127:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s op=%h actual=%h expected=%h", req, x, got, exp_v);
    end
  endtask

  task automatic check_one(input logic [31:0] x, input logic [95:0] up, input logic [127:0] got);
    logic [7:0]  e;
    logic [22:0] f;
    logic [31:0] lo;
    e  = x[30:23];
    f  = x[22:0];
    lo = got[31:0];
    report(got[127:32] == up, "R7 upper lane", x, {got[127:32], 32'd0}, {up, 32'd0});
    if (e == 8'h00)
      report(lo == {x[31], 8'hFF, 23'd0}, "R2 zero/denormal", x, {96'd0, lo}, {96'd0, x[31], 8'hFF, 23'd0});
    else if (e == 8'hFF && f == '0)
      report(lo == {x[31], 31'd0}, "R3 infinity", x, {96'd0, lo}, {96'd0, x[31], 31'd0});
    else if (e == 8'hFF)
      report(lo == (x | 32'h0040_0000), "R4 NaN", x, {96'd0, lo}, {96'd0, x | 32'h0040_0000});
    else if (e > 8'd253 || (e == 8'd253 && f >= FLUSH_FRAC))
      report(lo == {x[31], 31'd0}, "R5 flush", x, {96'd0, lo}, {96'd0, x[31], 31'd0});
    else if (f == '0 && e <= 8'd252)
      report(lo == {x[31], 8'(9'd254 - 9'(e)), 23'd0}, "R6 power of two", x,
             {96'd0, lo}, {96'd0, x[31], 8'(9'd254 - 9'(e)), 23'd0});
    else if (e < 8'd252 || (e == 8'd252 && f <= KEEP_FRAC))
      report(err_ok(x, lo), "R1 error bound / R5 no flush", x, {96'd0, lo}, {96'd0, x[31], 31'h7FFF_FFFF});
    else
      report(lo == {x[31], 31'd0} || err_ok(x, lo), "R5 between bounds", x, {96'd0, lo}, {96'd0, x[31], 31'd0});
  endtask

  // Output side: sampled at the falling edge, inputs move 1 ns later
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_op.size() == 0) begin
        report(1'b0, "R8 unexpected out_valid", 32'd0, {127'd0, out_valid}, 128'd0);
      end else begin
        logic [31:0] x;
        logic [95:0] up;
        int unsigned c;
        x = q_op.pop_front(); up = q_up.pop_front(); c = q_cyc.pop_front();
        report(cyc == c + 2, "R8 latency", x, 128'(cyc), 128'(c + 2));
        check_one(x, up, out_res);
      end
    end
  end

  task automatic drive(input logic [31:0] x, input bit v);
    @(negedge clk);
    #1;
    in_valid = v;
    in_op    = x;
    in_mode  = 1'($urandom);
    in_merge = {$urandom, $urandom, $urandom, $urandom};
    if (v) begin
      q_op.push_back(x);
      q_up.push_back(in_merge[127:32]);
      q_cyc.push_back(cyc);
    end
  endtask

  function automatic logic [31:0] rand_op();
    logic [31:0] r;
    int unsigned k;
    r = $urandom;
    k = $urandom % 8;
    case (k)
      0:       r[30:23] = 8'd252 + 8'($urandom % 2);      // flush region edge
      1:       r[30:23] = 8'(($urandom % 2) * 255);       // zero/denormal/inf/NaN
      2:       r[22:0]  = 23'd0;                          // powers of two
      default: ;
    endcase
    return r;
  endfunction

  logic [31:0] directed [24] = '{
    32'h3F80_0000, 32'h4000_0000, 32'hBF00_0000, 32'h4040_0000, 32'h3FC0_0000,
    32'h3FFF_FFFF, 32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF,
    32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0001, 32'hFFC1_2345, 32'h7FC0_0000,
    {1'b0, 8'd252, KEEP_FRAC}, {1'b1, 8'd253, FLUSH_FRAC}, {1'b0, 8'd253, 23'd0},
    32'h7F00_0000, 32'hFF7F_FFFF, 32'h0080_0000, 32'h8080_0001, 32'h7E7F_FFFF,
    32'h4B80_0000
  };

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9 reset state
    report(out_valid == 1'b0 && out_res == '0, "R9 reset", 32'd0, out_res, 128'd0);
    #1 rst_n = 1'b1;
    foreach (directed[i]) drive(directed[i], 1'b1);
    for (int i = 0; i < 3000; i++) drive(rand_op(), ($urandom % 8) != 0);
    drive(32'd0, 1'b0);
    repeat (4) @(negedge clk);
    // R8: every accepted operand produced exactly one result
    report(q_op.size() == 0, "R8 all results returned", 32'd0, 128'(q_op.size()), 128'd0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule